// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It presents the program counter on an instruction fetch port and takes back the 32-bit instruction word in the same cycle. It drives a data port with a byte address, write data and four byte write enables, and it takes read data back in the same cycle. Both memories sit outside the core and must answer combinationally.

The core recognises a fixed subset of instructions:

- register-register add, subtract and signed set-less-than;
- add-immediate, signed set-less-than-immediate and upper-immediate load;
- word and byte loads and stores;
- equal and not-equal branches;
- absolute jump, jump-and-link, and return through a register.

State is a 32-entry register file, in which entry 0 is fixed at zero, and the program counter. An opcode outside the subset retires as a no-op. There are no delay slots, so a taken branch or jump redirects the very next fetch.

Top module: `lsc_core`

## Requirements
- R1: While rst_n is low at a clock edge the program counter becomes 0, so imem_addr reads 0 after that edge.
- R2: Register 0 reads as zero at all times. A write that names register 0 is discarded.
- R3: A word with op 000000 is register-register, with fields rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Funct 100000 writes rd = rs + rt and funct 100010 writes rd = rs - rt, both modulo 2^32.
- R4: Op 001000 (add-immediate) writes rt = rs + imm, where imm[15:0] is sign-extended to 32 bits.
- R5: Funct 101010 writes rd = 1 if rs < rt as signed values, else 0. Op 001010 writes rt = 1 if rs < sign-extended imm (signed), else 0.
- R6: Op 001111 writes rt = {imm[15:0], 16'h0000}.
- R7: Op 000100 branches when rs == rt and op 000101 branches when rs != rt. A taken branch sets PC = PC + 4 + sext(imm) * 4, which also covers backward offsets. A branch not taken, and any other non-control instruction, sets PC = PC + 4.
- R8: Op 000010 sets PC = {PC+4[31:28], target[25:0], 2'b00}. Op 000011 does the same and also writes PC + 4 into register 31. Op 000000 with funct 001000 sets PC to the value of register rs.
- R9: Op 100011 loads the aligned word at rs + sext(imm) into rt. Op 101011 stores rt there with dmem_be = 4'b1111 and dmem_addr = rs + sext(imm).
- R10: Op 101000 stores rt[7:0] with exactly one enable, bit addr[1:0] (little-endian lanes), and with the byte copied to all four lanes of dmem_wdata. Op 100000 loads the byte of lane addr[1:0] and sign-extends it into rt.
- R11: An unsupported opcode or funct writes no register, drives no store and advances PC by 4.
- R12: dmem_be is 4'b0000 in every cycle that does not execute a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data, with the byte copied to every lane for byte stores |
| dmem_be | output | 4 | Per-byte write enables; bit n writes byte n |
| dmem_rdata | input | 32 | Word read at dmem_addr, same cycle |

## Verification
Store outputs (dmem_addr, dmem_wdata, dmem_be) are combinational from the fetched word, so they are due in the same cycle the instruction is presented. The program-counter effect of an instruction appears on imem_addr one edge later. Register results are not visible directly: they show up only in the addresses and data of later stores, and in a final block of stores that dumps the registers to memory.

The bench steps a behavioural model once per cycle at the falling edge. There it compares imem_addr with the model's PC, compares the store signals with what the current word should produce, and only then advances the model. Each comparison therefore sits half a cycle after the edge that produced the value. At the end, every data memory word is compared with the model's memory.

// File: rtl/lsc_pkg.sv
// Package lsc_pkg
// Shared encodings, control enums and the decoded control bundle for the
// single-cycle core. Assumes a 32-bit word and 5-bit register index fields.
package lsc_pkg;
    localparam int XLEN  = 32;
    localparam int NLANE = XLEN / 8;

    localparam logic [5:0] OP_REG  = 6'b000000;
    localparam logic [5:0] OP_J    = 6'b000010;
    localparam logic [5:0] OP_JAL  = 6'b000011;
    localparam logic [5:0] OP_BEQ  = 6'b000100;
    localparam logic [5:0] OP_BNE  = 6'b000101;
    localparam logic [5:0] OP_ADDI = 6'b001000;
    localparam logic [5:0] OP_SLTI = 6'b001010;
    localparam logic [5:0] OP_LUI  = 6'b001111;
    localparam logic [5:0] OP_LB   = 6'b100000;
    localparam logic [5:0] OP_LW   = 6'b100011;
    localparam logic [5:0] OP_SB   = 6'b101000;
    localparam logic [5:0] OP_SW   = 6'b101011;

    localparam logic [5:0] FN_JR  = 6'b001000;
    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_SLT = 6'b101010;

    localparam logic [4:0] LINK_REG = 5'd31;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_LUI} alu_op_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
    typedef enum logic [2:0] {NX_SEQ, NX_BEQ, NX_BNE, NX_JUMP, NX_JREG} nx_sel_e;

    typedef struct packed {
        logic       wb_en;
        logic [4:0] wb_addr;
        wb_sel_e    wb_sel;
        alu_op_e    alu_op;
        logic       use_imm;
        logic       mem_rd;
        logic       mem_wr;
        logic       mem_byte;
        nx_sel_e    nx_sel;
    } ctrl_t;
endpackage

// File: rtl/lsc_regfile.sv
// Module lsc_regfile
// Two read ports, one write port. Reads are combinational and the write lands
// on the rising edge. Entry 0 is never written, and reset clears all entries,
// so entry 0 reads zero for ever. Assumes NREG is a power of two.
module lsc_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] regs [NREG];

    // Storage update: clear on reset, otherwise write any entry except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read ports: direct array lookup.
    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    p_zero_read_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == '0) |-> (rd_a == '0));
    p_zero_read_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_b == '0) |-> (rd_b == '0));
endmodule

// File: rtl/lsc_decode.sv
// Module lsc_decode
// Turns an instruction word into a control bundle, the register indices and
// the sign-extended immediate. Any unrecognised op or funct yields the
// all-quiet bundle: no write-back, no memory access, sequential PC.
module lsc_decode
    import lsc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl,
    output logic [4:0]      rs_idx,
    output logic [4:0]      rt_idx,
    output logic [XLEN-1:0] imm_sx
);
    logic [5:0] op;
    logic [5:0] fn;
    logic [4:0] rd_idx;

    assign op     = instr[31:26];
    assign fn     = instr[5:0];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

    // Control generation: start from a quiet bundle, then enable per opcode.
    always_comb begin
        ctrl          = '0;
        ctrl.wb_sel   = WB_ALU;
        ctrl.alu_op   = ALU_ADD;
        ctrl.nx_sel   = NX_SEQ;
        case (op)
            OP_REG: begin
                case (fn)
                    FN_ADD: begin
                        ctrl.wb_en   = 1'b1;
                        ctrl.wb_addr = rd_idx;
                    end
                    FN_SUB: begin
                        ctrl.wb_en   = 1'b1;
                        ctrl.wb_addr = rd_idx;
                        ctrl.alu_op  = ALU_SUB;
                    end
                    FN_SLT: begin
                        ctrl.wb_en   = 1'b1;
                        ctrl.wb_addr = rd_idx;
                        ctrl.alu_op  = ALU_SLT;
                    end
                    FN_JR:   ctrl.nx_sel = NX_JREG;
                    default: ;
                endcase
            end
            OP_ADDI: begin
                ctrl.wb_en   = 1'b1;
                ctrl.wb_addr = rt_idx;
                ctrl.use_imm = 1'b1;
            end
            OP_SLTI: begin
                ctrl.wb_en   = 1'b1;
                ctrl.wb_addr = rt_idx;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
            end
            OP_LUI: begin
                ctrl.wb_en   = 1'b1;
                ctrl.wb_addr = rt_idx;
                ctrl.alu_op  = ALU_LUI;
            end
            OP_LW, OP_LB: begin
                ctrl.wb_en    = 1'b1;
                ctrl.wb_addr  = rt_idx;
                ctrl.use_imm  = 1'b1;
                ctrl.mem_rd   = 1'b1;
                ctrl.wb_sel   = WB_MEM;
                ctrl.mem_byte = (op == OP_LB);
            end
            OP_SW, OP_SB: begin
                ctrl.use_imm  = 1'b1;
                ctrl.mem_wr   = 1'b1;
                ctrl.mem_byte = (op == OP_SB);
            end
            OP_BEQ: ctrl.nx_sel = NX_BEQ;
            OP_BNE: ctrl.nx_sel = NX_BNE;
            OP_J:   ctrl.nx_sel = NX_JUMP;
            OP_JAL: begin
                ctrl.nx_sel  = NX_JUMP;
                ctrl.wb_en   = 1'b1;
                ctrl.wb_addr = LINK_REG;
                ctrl.wb_sel  = WB_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsc_lsu.sv
// Module lsc_lsu
// Byte-lane steering for the data port. Stores: word stores enable all lanes,
// byte stores enable the one lane picked by the low address bits and copy the
// byte to every lane. Loads: a byte load picks its lane and sign-extends it.
// Assumes little-endian lane numbering and aligned word accesses.
module lsc_lsu #(
    parameter int DW    = 32,
    parameter int LANES = DW / 8,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [LW-1:0]    lane_sel,
    input  logic             mem_wr,
    input  logic             mem_byte,
    input  logic [DW-1:0]    store_data,
    input  logic [DW-1:0]    rdata,
    output logic [LANES-1:0] be,
    output logic [DW-1:0]    wdata,
    output logic [DW-1:0]    load_val
);
    logic [7:0] lane_byte [LANES];
    logic [7:0] picked;

    // Split the read word into lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = rdata[8*g +: 8];
    end

    // Write-enable generation.
    always_comb begin
        be = '0;
        if (mem_wr) be = mem_byte ? (LANES'(1) << lane_sel) : '1;
    end

    // Store data: full word, or the low byte copied to all lanes.
    assign wdata    = mem_byte ? {LANES{store_data[7:0]}} : store_data;

    // Load data: full word, or the chosen lane sign-extended.
    assign picked   = lane_byte[lane_sel];
    assign load_val = mem_byte ? {{(DW-8){picked[7]}}, picked} : rdata;
endmodule

// File: rtl/lsc_core.sv
// Module lsc_core
// Single-cycle core top. Fetch, decode, register read, ALU, data access and
// write-back all happen inside one clock period. The PC and the register file
// update on the rising edge. Assumes both memories answer combinationally and
// that instruction addresses are word aligned. There is no delay slot.
module lsc_core
    import lsc_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [XLEN-1:0]  imem_rdata,
    output logic [XLEN-1:0]  dmem_addr,
    output logic [XLEN-1:0]  dmem_wdata,
    output logic [NLANE-1:0] dmem_be,
    input  logic [XLEN-1:0]  dmem_rdata
);
    localparam int LW = $clog2(NLANE);

    ctrl_t           ctrl;
    logic [4:0]      rs_idx, rt_idx;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target, j_target;
    logic [XLEN-1:0] rs_v, rt_v, alu_b, alu_y, load_val, rf_wd;

    lsc_decode u_decode (
        .instr  (imem_rdata),
        .ctrl   (ctrl),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .imm_sx (imm_sx)
    );

    lsc_regfile #(.NREG(NREG), .DW(XLEN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (rs_idx),
        .ra_b  (rt_idx),
        .rd_a  (rs_v),
        .rd_b  (rt_v),
        .we    (ctrl.wb_en),
        .wa    (ctrl.wb_addr),
        .wd    (rf_wd)
    );

    // ALU: add, subtract, signed compare, upper-immediate placement.
    assign alu_b = ctrl.use_imm ? imm_sx : rt_v;
    always_comb begin
        case (ctrl.alu_op)
            ALU_SUB: alu_y = rs_v - alu_b;
            ALU_SLT: alu_y = {{(XLEN-1){1'b0}}, ($signed(rs_v) < $signed(alu_b))};
            ALU_LUI: alu_y = {imm_sx[15:0], 16'h0000};
            default: alu_y = rs_v + alu_b;
        endcase
    end

    lsc_lsu #(.DW(XLEN)) u_lsu (
        .lane_sel   (alu_y[LW-1:0]),
        .mem_wr     (ctrl.mem_wr),
        .mem_byte   (ctrl.mem_byte),
        .store_data (rt_v),
        .rdata      (dmem_rdata),
        .be         (dmem_be),
        .wdata      (dmem_wdata),
        .load_val   (load_val)
    );
    assign dmem_addr = alu_y;

    // Write-back source selection.
    always_comb begin
        case (ctrl.wb_sel)
            WB_MEM:  rf_wd = load_val;
            WB_LINK: rf_wd = pc_plus4;
            default: rf_wd = alu_y;
        endcase
    end

    // Next-PC candidates and selection.
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
    always_comb begin
        case (ctrl.nx_sel)
            NX_BEQ:  pc_d = (rs_v == rt_v) ? br_target : pc_plus4;
            NX_BNE:  pc_d = (rs_v != rt_v) ? br_target : pc_plus4;
            NX_JUMP: pc_d = j_target;
            NX_JREG: pc_d = rs_v;
            default: pc_d = pc_plus4;
        endcase
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
    assign imem_addr = pc_q;

    p_seq_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.nx_sel == NX_SEQ) |=> (pc_q == $past(pc_q) + XLEN'(4)));
    p_jreg_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.nx_sel == NX_JREG) |=> (pc_q == $past(rs_v)));
    p_jump_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.nx_sel == NX_JUMP) |=> ((pc_q[31:28] == $past(pc_plus4[31:28])) && (pc_q[1:0] == 2'b00)));
    p_lane_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_be != '0) |-> (($countones(dmem_be) == 1) || (dmem_be == '1)));
    p_quiet_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.mem_wr) |-> (dmem_be == '0));
endmodule

// File: tb/lsc_core_bench.sv
`timescale 1ns/1ps
// Bench for lsc_core: behavioural instruction-level model stepped in lockstep
// with the design, compared at every falling edge, plus a final memory sweep.
module lsc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0]  dmem_be;

    logic [31:0] prog  [256];
    logic [31:0] dmem  [256];
    logic [31:0] m_mem [256];
    logic [31:0] m_r   [32];
    logic [31:0] m_pc;
    string       pc_tag;
    string       slot_tag [32];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    lsc_core u_lsc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_be    (dmem_be),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = prog[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    // Behavioural data memory: cleared in reset, byte writes by enable.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dmem[i] <= 32'h0;
        end else begin
            for (int l = 0; l < 4; l++)
                if (dmem_be[l]) dmem[dmem_addr[9:2]][8*l +: 8] <= dmem_wdata[8*l +: 8];
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int op, int word_addr);
        return {6'(op), 26'(word_addr)};
    endfunction

    task automatic set_reg(int idx, logic [31:0] v);
        if (idx != 0) m_r[idx] = v;
    endtask

    // One model step: check the store port for the current word, then retire it.
    task automatic step_and_check();
        logic [31:0] w, a, b, sx, ea, npc, byt;
        logic [3:0]  exp_be;
        int op, fn, rs, rt, rd;
        string tag;
        w  = prog[m_pc[9:2]];
        op = int'(w[31:26]); fn = int'(w[5:0]);
        rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
        a  = m_r[rs]; b = m_r[rt];
        sx = {{16{w[15]}}, w[15:0]};
        ea = a + sx;
        npc = m_pc + 32'd4;
        tag = "R3";
        exp_be = 4'b0000;
        case (op)
            0: begin
                if (fn == 32)      set_reg(rd, a + b);
                else if (fn == 34) set_reg(rd, a - b);
                else if (fn == 42) begin set_reg(rd, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0); tag = "R5"; end
                else if (fn == 8)  begin npc = a; tag = "R8"; end
                else tag = "R11";
            end
            8:  begin set_reg(rt, ea); tag = "R4"; end
            10: begin set_reg(rt, ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0); tag = "R5"; end
            15: begin set_reg(rt, {w[15:0], 16'h0}); tag = "R6"; end
            35: begin set_reg(rt, m_mem[ea[9:2]]); tag = "R9"; end
            32: begin
                byt = (m_mem[ea[9:2]] >> (8 * ea[1:0])) & 32'hFF;
                set_reg(rt, {{24{byt[7]}}, byt[7:0]}); tag = "R10";
            end
            43: begin
                exp_be = 4'b1111;
                chk("R9", "sw addr", dmem_addr, ea);
                chk("R9", "sw data", dmem_wdata, b);
                m_mem[ea[9:2]] = b; tag = "R9";
            end
            40: begin
                exp_be = 4'b0001 << ea[1:0];
                chk("R10", "sb addr", dmem_addr, ea);
                chk("R10", "sb data", dmem_wdata, {4{b[7:0]}});
                m_mem[ea[9:2]][8*ea[1:0] +: 8] = b[7:0]; tag = "R10";
            end
            4:  begin if (a == b) npc = npc + (sx << 2); tag = "R7"; end
            5:  begin if (a != b) npc = npc + (sx << 2); tag = "R7"; end
            2:  begin npc = {npc[31:28], w[25:0], 2'b00}; tag = "R8"; end
            3:  begin set_reg(31, npc); npc = {npc[31:28], w[25:0], 2'b00}; tag = "R8"; end
            default: tag = "R11";
        endcase
        chk((exp_be == 4'b0000) ? "R12" : tag, "dmem_be", {28'h0, dmem_be}, {28'h0, exp_be});
        m_pc   = npc;
        pc_tag = tag;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin prog[i] = 32'h0; m_mem[i] = 32'h0; end
        for (int i = 0; i < 32; i++) begin m_r[i] = 32'h0; slot_tag[i] = "R9"; end
        prog[0]  = enc_i(8, 0, 1, 5);
        prog[1]  = enc_i(8, 0, 2, -3);
        prog[2]  = enc_r(32, 1, 2, 3);
        prog[3]  = enc_r(34, 2, 1, 4);
        prog[4]  = enc_r(42, 2, 1, 5);
        prog[5]  = enc_i(10, 1, 6, -1);
        prog[6]  = enc_i(15, 0, 7, 'h8234);
        prog[7]  = enc_i(8, 0, 8, 'h100);
        prog[8]  = enc_i(43, 8, 7, 0);
        prog[9]  = enc_i(8, 0, 9, 'h1C5);
        prog[10] = enc_i(40, 8, 9, 1);
        prog[11] = enc_i(40, 8, 9, 6);
        prog[12] = enc_i(32, 8, 10, 1);
        prog[13] = enc_i(32, 8, 11, 3);
        prog[14] = enc_i(35, 8, 12, 0);
        prog[15] = enc_i(8, 0, 0, 7);
        prog[16] = enc_r(32, 0, 1, 13);
        prog[17] = enc_i(4, 1, 1, 1);
        prog[18] = enc_i(8, 0, 14, 99);
        prog[19] = enc_i(5, 1, 1, 5);
        prog[20] = enc_i(5, 1, 2, 1);
        prog[21] = enc_i(8, 0, 14, 77);
        prog[22] = enc_j(3, 60);
        prog[23] = 32'hFC21FFFF;
        prog[24] = enc_j(2, 26);
        prog[25] = enc_i(8, 0, 15, 1);
        prog[26] = enc_i(4, 2, 1, 3);
        for (int k = 1; k <= 18; k++) prog[26 + k] = enc_i(43, 0, k, 'h200 + 4 * k);
        prog[45] = enc_i(43, 0, 31, 'h200 + 4 * 31);
        prog[46] = enc_j(2, 46);
        prog[60] = enc_i(8, 0, 16, -1);
        prog[61] = enc_i(10, 2, 17, -2);
        prog[62] = enc_i(8, 0, 18, 2);
        prog[63] = enc_i(8, 18, 18, -1);
        prog[64] = enc_i(5, 18, 0, -2);
        prog[65] = enc_r(8, 31, 0, 0);
        slot_tag[1] = "R4";  slot_tag[2] = "R4";  slot_tag[3] = "R3";  slot_tag[4] = "R3";
        slot_tag[5] = "R5";  slot_tag[6] = "R5";  slot_tag[7] = "R6";  slot_tag[8] = "R4";
        slot_tag[9] = "R4";  slot_tag[10] = "R10"; slot_tag[11] = "R10"; slot_tag[12] = "R9";
        slot_tag[13] = "R2"; slot_tag[14] = "R7"; slot_tag[15] = "R8"; slot_tag[16] = "R8";
        slot_tag[17] = "R5"; slot_tag[18] = "R7"; slot_tag[31] = "R8";
        m_pc = 32'h0;
        pc_tag = "R1";

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc after reset", imem_addr, 32'h0);
        chk("R12", "be in reset", {28'h0, dmem_be}, 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < 150; c++) begin
            chk(pc_tag, "pc", imem_addr, m_pc);
            step_and_check();
            @(negedge clk);
        end
        for (int i = 0; i < 256; i++) begin
            string t;
            t = (i >= 128 && i < 160) ? slot_tag[i - 128] : "R10";
            if (i == 64) t = "R9";
            chk(t, $sformatf("mem word %0d", i), dmem[i], m_mem[i]);
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule